// File: doc/BRIEF.md
# Stripe Parity Generator and Single-Member Rebuilder

This block serves an array of storage members striped across N positions. For each stripe it receives one word per member, works out which member holds that stripe's parity, and produces the XOR of the data members. If a failed member is flagged, it also rebuilds that member's word by XORing all the other members. A parity word that is already stored at the parity position passes through the same XOR as the data, so one datapath both generates parity and repairs any single lost member.

There are two placement modes. In fixed mode, the last member always holds parity. In rotating mode, the parity position moves down by one member for each new stripe and wraps every N stripes. This spreads parity updates across all members. The block accepts one stripe per cycle and gives registered results one cycle later.

Top module: `raid_parity_rebuild`

## Requirements
- R1: `parity_o` is the bitwise XOR of every member word except the one at the parity position. For example, with data words 8'b1001_1001 and 8'b1000_1100 and all other data words zero, it is 8'b0001_0101.
- R2: When `fail_vld_i` is 1 and `fail_idx_i` is below N, `rebuilt_o` is the XOR of every member word except the one at `fail_idx_i`. With the example above stored at the parity position, rebuilding member 0 gives 8'b1001_1001.
- R3: When `mode_i` is 0 (fixed), `par_idx_o` is N-1 for every stripe.
- R4: When `mode_i` is 1 (rotating), `par_idx_o` is (N-1) - (`stripe_i` mod N).
- R5: When the flagged failed member is the parity position, `rebuilt_o` equals `parity_o`.
- R6: When `fail_vld_i` is 1 and `fail_idx_i` is N or greater, `err_o` is 1 and `rebuilt_o` is zero.
- R7: `valid_o` is `valid_i` delayed by exactly one cycle. While `valid_i` is 0, the result outputs keep their last values.
- R8: After reset, `valid_o`, `err_o`, `parity_o`, `par_idx_o` and `rebuilt_o` are all zero.
- R9: When `fail_vld_i` is 0, `rebuilt_o` is zero and `err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Stripe inputs are valid this cycle |
| mode_i | input | 1 | 0 = fixed parity position, 1 = rotating parity position |
| stripe_i | input | STRIPE_W | Stripe number |
| members_i | input | N*WORD_W | Member words; member k is in bits [k*WORD_W +: WORD_W] |
| fail_vld_i | input | 1 | A failed member is flagged |
| fail_idx_i | input | $clog2(N+1) | Index of the failed member |
| valid_o | output | 1 | Results are valid |
| parity_o | output | WORD_W | XOR of the data members |
| par_idx_o | output | $clog2(N+1) | Member that holds parity for this stripe |
| rebuilt_o | output | WORD_W | Rebuilt word of the failed member |
| err_o | output | 1 | Failed index is out of range |

## Verification
The bench builds the block with N=5, WORD_W=8 and STRIPE_W=8. Because five is not a power of two, the general modulo path of the parity-position logic is used, and the rotation is seen wrapping at stripes 5 and 10. With a 3-bit index, the failed-member values 5, 6 and 7 exist on the port, so the out-of-range error can be driven. The 8-bit word width allows the two-data-word example to be applied exactly, with the remaining data members held at zero.

// File: rtl/raid_pkg.sv
package raid_pkg;
  typedef enum logic {
    PAR_FIXED  = 1'b0,
    PAR_ROTATE = 1'b1
  } par_mode_e;
endpackage

// File: rtl/raid_par_loc.sv
module raid_par_loc #(
  parameter int N        = 4,
  parameter int STRIPE_W = 16,
  parameter int IDX_W    = $clog2(N + 1)
) (
  input  logic                mode_i,
  input  logic [STRIPE_W-1:0] stripe_i,
  output logic [IDX_W-1:0]    par_idx_o
);
  import raid_pkg::*;

  localparam logic [STRIPE_W-1:0] N_S   = STRIPE_W'(N);
  localparam bit                  POW2  = (N & (N - 1)) == 0;
  localparam int                  LOG_N = (N > 1) ? $clog2(N) : 1;

  logic [STRIPE_W-1:0] rem;

  generate
    if (POW2) begin : g_mask
      // power-of-two member count: modulo is a bit mask
      assign rem = stripe_i & (N_S - STRIPE_W'(1));
    end else begin : g_mod
      assign rem = stripe_i % N_S;
    end
  endgenerate

  logic [STRIPE_W-1:0] rot_idx;
  assign rot_idx = N_S - STRIPE_W'(1) - rem;

  always_comb begin
    if (par_mode_e'(mode_i) == PAR_ROTATE) par_idx_o = IDX_W'(rot_idx);
    else                                   par_idx_o = IDX_W'(N - 1);
  end

  logic unused_log;
  assign unused_log = ^LOG_N;
endmodule

// File: rtl/raid_xor_fold.sv
module raid_xor_fold #(
  parameter int N      = 4,
  parameter int WORD_W = 32
) (
  input  logic [N*WORD_W-1:0] words_i,
  input  logic [N-1:0]        keep_i,
  output logic [WORD_W-1:0]   fold_o
);
  always_comb begin
    fold_o = '0;
    for (int k = 0; k < N; k++) begin
      if (keep_i[k]) fold_o = fold_o ^ words_i[k*WORD_W +: WORD_W];
    end
  end
endmodule

// File: rtl/raid_parity_rebuild.sv
module raid_parity_rebuild #(
  parameter int N        = 4,
  parameter int WORD_W   = 32,
  parameter int STRIPE_W = 16,
  localparam int IDX_W   = $clog2(N + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                mode_i,
  input  logic [STRIPE_W-1:0] stripe_i,
  input  logic [N*WORD_W-1:0] members_i,
  input  logic                fail_vld_i,
  input  logic [IDX_W-1:0]    fail_idx_i,
  output logic                valid_o,
  output logic [WORD_W-1:0]   parity_o,
  output logic [IDX_W-1:0]    par_idx_o,
  output logic [WORD_W-1:0]   rebuilt_o,
  output logic                err_o
);
  logic [IDX_W-1:0]  par_idx_d;
  logic [N-1:0]      par_keep, fail_keep;
  logic [WORD_W-1:0] par_fold, fail_fold, rebuilt_d;
  logic              err_d;

  raid_par_loc #(.N(N), .STRIPE_W(STRIPE_W), .IDX_W(IDX_W)) i_loc (
    .mode_i   (mode_i),
    .stripe_i (stripe_i),
    .par_idx_o(par_idx_d)
  );

  assign par_keep  = ~(N'(1) << par_idx_d);
  assign fail_keep = ~(N'(1) << fail_idx_i);

  raid_xor_fold #(.N(N), .WORD_W(WORD_W)) i_par_fold (
    .words_i(members_i),
    .keep_i (par_keep),
    .fold_o (par_fold)
  );

  raid_xor_fold #(.N(N), .WORD_W(WORD_W)) i_fail_fold (
    .words_i(members_i),
    .keep_i (fail_keep),
    .fold_o (fail_fold)
  );

  assign err_d     = fail_vld_i && (fail_idx_i >= IDX_W'(N));
  assign rebuilt_d = (fail_vld_i && !err_d) ? fail_fold : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      parity_o  <= '0;
      par_idx_o <= '0;
      rebuilt_o <= '0;
      err_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        parity_o  <= par_fold;
        par_idx_o <= par_idx_d;
        rebuilt_o <= rebuilt_d;
        err_o     <= err_d;
      end
    end
  end

  a_r7_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r7_valid_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(parity_o) && $stable(rebuilt_o) && $stable(par_idx_o));
  a_r3_fixed_loc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !mode_i) |=> par_idx_o == IDX_W'(N - 1));
  a_r4_loc_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> par_idx_o < IDX_W'(N));
  a_r5_parity_rebuild: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && fail_vld_i && fail_idx_i == par_idx_d) |=> rebuilt_o == parity_o);
  a_r6_err_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rebuilt_o == '0);
  a_r9_no_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !fail_vld_i) |=> !err_o && rebuilt_o == '0);
endmodule

// File: tb/test_raid_parity_rebuild.sv
module test_raid_parity_rebuild;
  localparam int N        = 5;
  localparam int WORD_W   = 8;
  localparam int STRIPE_W = 8;
  localparam int IDX_W    = $clog2(N + 1);
  localparam time CLK_PERIOD = 10ns;

  logic                clk_i = 1'b0;
  logic                rst_ni = 1'b0;
  logic                valid_i = 1'b0;
  logic                mode_i = 1'b0;
  logic [STRIPE_W-1:0] stripe_i = '0;
  logic [N*WORD_W-1:0] members_i = '0;
  logic                fail_vld_i = 1'b0;
  logic [IDX_W-1:0]    fail_idx_i = '0;
  logic                valid_o;
  logic [WORD_W-1:0]   parity_o;
  logic [IDX_W-1:0]    par_idx_o;
  logic [WORD_W-1:0]   rebuilt_o;
  logic                err_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  raid_parity_rebuild #(.N(N), .WORD_W(WORD_W), .STRIPE_W(STRIPE_W)) i_raid_parity_rebuild (
    .clk_i, .rst_ni, .valid_i, .mode_i, .stripe_i, .members_i, .fail_vld_i, .fail_idx_i,
    .valid_o, .parity_o, .par_idx_o, .rebuilt_o, .err_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_loc(input logic m, input int s);
    return m ? (N - 1 - (s % N)) : (N - 1);
  endfunction

  function automatic logic [WORD_W-1:0] fold_except(input logic [N*WORD_W-1:0] w, input int skip);
    logic [WORD_W-1:0] r = '0;
    for (int k = 0; k < N; k++) if (k != skip) r ^= w[k*WORD_W +: WORD_W];
    return r;
  endfunction

  task automatic apply(input logic m, input int s, input logic [N*WORD_W-1:0] w,
                       input logic fv, input int fi);
    @(negedge clk_i);
    valid_i = 1'b1; mode_i = m; stripe_i = STRIPE_W'(s); members_i = w;
    fail_vld_i = fv; fail_idx_i = IDX_W'(fi);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 valid", 32'(valid_o), 0);
    check("R8 err", 32'(err_o), 0);
    check("R8 parity", 32'(parity_o), 0);
    check("R8 loc", 32'(par_idx_o), 0);
    check("R8 rebuilt", 32'(rebuilt_o), 0);
  endtask

  task automatic t_example;
    logic [N*WORD_W-1:0] w = '0;
    w[0*WORD_W +: WORD_W] = 8'b1001_1001;
    w[1*WORD_W +: WORD_W] = 8'b1000_1100;
    apply(1'b0, 0, w, 1'b0, 0);
    check("R1 example parity", 32'(parity_o), 32'h15);
    check("R7 valid after input", 32'(valid_o), 1);
    w[4*WORD_W +: WORD_W] = 8'b0001_0101;
    apply(1'b0, 0, w, 1'b1, 0);
    check("R2 example rebuild", 32'(rebuilt_o), 32'h99);
  endtask

  task automatic t_fixed;
    for (int i = 0; i < 8; i++) begin
      logic [N*WORD_W-1:0] w = {$urandom, $urandom};
      apply(1'b0, i * 37, w, 1'b1, i % N);
      check("R3 fixed loc", 32'(par_idx_o), 32'(N - 1));
      check("R1 fixed parity", 32'(parity_o), 32'(fold_except(w, N - 1)));
      check("R2 fixed rebuild", 32'(rebuilt_o), 32'(fold_except(w, i % N)));
      check("R9 err low", 32'(err_o), 0);
    end
  endtask

  task automatic t_rotate;
    for (int s = 0; s < 12; s++) begin
      logic [N*WORD_W-1:0] w = {$urandom, $urandom};
      apply(1'b1, s, w, 1'b1, (s + 2) % N);
      check("R4 rotate loc", 32'(par_idx_o), 32'(exp_loc(1'b1, s)));
      check("R1 rotate parity", 32'(parity_o), 32'(fold_except(w, exp_loc(1'b1, s))));
      check("R2 rotate rebuild", 32'(rebuilt_o), 32'(fold_except(w, (s + 2) % N)));
    end
    apply(1'b1, 255, '0, 1'b0, 0);
    check("R4 rotate loc top stripe", 32'(par_idx_o), 32'(exp_loc(1'b1, 255)));
  endtask

  task automatic t_parity_fail;
    for (int s = 3; s < 7; s++) begin
      logic [N*WORD_W-1:0] w = {$urandom, $urandom};
      apply(1'b1, s, w, 1'b1, exp_loc(1'b1, s));
      check("R5 rebuilt equals parity", 32'(rebuilt_o), 32'(parity_o));
      check("R5 rebuilt value", 32'(rebuilt_o), 32'(fold_except(w, exp_loc(1'b1, s))));
    end
  endtask

  task automatic t_error;
    for (int fi = N; fi < (1 << IDX_W); fi++) begin
      apply(1'b0, fi, {$urandom, $urandom}, 1'b1, fi);
      check("R6 err high", 32'(err_o), 1);
      check("R6 rebuilt zero", 32'(rebuilt_o), 0);
    end
    apply(1'b0, 1, {$urandom, $urandom}, 1'b0, 6);
    check("R9 err low without flag", 32'(err_o), 0);
    check("R9 rebuilt zero without flag", 32'(rebuilt_o), 0);
  endtask

  task automatic t_hold;
    logic [N*WORD_W-1:0] w = {32'h1234_5678, 8'h9a};
    logic [WORD_W-1:0] p, r;
    apply(1'b1, 2, w, 1'b1, 1);
    p = parity_o; r = rebuilt_o;
    members_i = ~w; stripe_i = 8'd3; fail_idx_i = 3'd2;
    @(negedge clk_i);
    check("R7 valid low", 32'(valid_o), 0);
    check("R7 parity held", 32'(parity_o), 32'(p));
    check("R7 rebuilt held", 32'(rebuilt_o), 32'(r));
    check("R7 loc held", 32'(par_idx_o), 32'(exp_loc(1'b1, 2)));
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_example();
    t_fixed();
    t_rotate();
    t_parity_fail();
    t_error();
    t_hold();
    finish_run();
  end
endmodule